// File: doc/BRIEF.md
# Multicycle Control Sequencer with Shared ALU

This block is the control unit of a small multicycle processor core. The core has one memory for both instructions and data, and one ALU. That same ALU also advances the program counter and computes branch targets, so the core needs no separate adder. Each cycle the sequencer reads the current opcode, the function code and the ALU zero flag. It then drives the strobes and selects that steer the datapath: which address the memory sees, which registers load, and what the ALU computes. The register file, the memory contents and the ALU arithmetic are outside this block.

Every instruction starts with a fetch cycle. In that cycle the ALU adds 4 to the PC and the PC takes the sum, whatever the instruction turns out to be. The next cycle is decode. There the ALU adds the updated PC to the sign-extended offset shifted left by two, and a target register keeps that sum before the instruction type is known. A branch then only compares its two registers. On equality the PC loads from the target register; otherwise the PC keeps PC+4. A jump builds its address from its own field and bypasses the target register. All pins are plain control pins with no handshake. The opcode and function code are assumed to come from the instruction register, so they hold steady from the decode cycle until the next fetch.

Top module: `mcyc_ctrl`

## Requirements
- R1: While reset is low, and in every fetch cycle, the outputs are: mem_rd=1, ir_we=1, pc_we=1, pc_src=0 (ALU result), mem_addr_alu=0 (PC as address), alu_a_reg=0 (PC), alu_b_sel=1 (constant 4) and alu_op=010 (add). All other strobes are 0. In any cycle that does not use the ALU, alu_a_reg=0, alu_b_sel=0 and alu_op=010.
- R2: The cycle after every fetch is decode. Decode gives tgt_we=1, alu_a_reg=0, alu_b_sel=3 (sign-extended offset shifted left by 2) and alu_op=010, with no memory, register-file or PC write.
- R3: Opcode 0x23 (load) takes 5 cycles: fetch, decode, address, read, write-back. Address gives alu_a_reg=1 and alu_b_sel=2 (sign-extended immediate) with add. Read gives mem_addr_alu=1 and mem_rd=1. Write-back gives rf_we=1, rf_src_mem=1 and rf_dst_rd=0. The cycle after write-back is fetch.
- R4: Opcode 0x2B (store) takes 4 cycles: fetch, decode, address (same selects as in R3), then write with mem_addr_alu=1 and mem_wr=1. The cycle after the write is fetch.
- R5: Opcode 0x00 (register type) takes 4 cycles: fetch, decode, execute (alu_a_reg=1, alu_b_sel=0), then write-back with rf_we=1, rf_dst_rd=1 and rf_src_mem=0. The cycle after write-back is fetch.
- R6: In execute, alu_op follows the function code: 0x20 gives 010, 0x22 gives 110, 0x24 gives 000, 0x25 gives 001 and 0x2A gives 111. Any other function code gives 010. In every other cycle the function code has no effect on the outputs.
- R7: Opcode 0x04 (branch if equal) takes 3 cycles: fetch, decode, compare. Compare gives alu_a_reg=1, alu_b_sel=0 and alu_op=110. When alu_zero=1 it also gives pc_we=1 and pc_src=1 (target register).
- R8: In compare with alu_zero=0, pc_we=0 and pc_src=0. Outside compare, alu_zero has no effect on the outputs.
- R9: Opcode 0x02 (jump) takes 3 cycles: fetch, decode, jump. Jump gives pc_we=1, pc_src=2 (jump field) and tgt_we=0.
- R10: Any other opcode goes from decode straight back to fetch and asserts no write strobe after decode.
- R11: At most one of mem_wr, rf_we, tgt_we and ir_we is high in any cycle, and mem_rd and mem_wr are never high together.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| opcode | input | 6 | Opcode of the current instruction |
| funct | input | 6 | Function code of a register-type instruction |
| alu_zero | input | 1 | ALU result equals zero |
| mem_addr_alu | output | 1 | Memory address select: 0 = PC, 1 = ALU result |
| mem_rd | output | 1 | Memory read strobe |
| mem_wr | output | 1 | Memory write strobe |
| ir_we | output | 1 | Instruction register load |
| pc_we | output | 1 | PC load |
| pc_src | output | 2 | PC source: 0 = ALU, 1 = target register, 2 = jump field |
| tgt_we | output | 1 | Target register load |
| rf_we | output | 1 | Register file write |
| rf_dst_rd | output | 1 | Destination select: 1 = rd field, 0 = rt field |
| rf_src_mem | output | 1 | Write data select: 1 = memory data, 0 = ALU output |
| alu_a_reg | output | 1 | ALU A operand: 0 = PC, 1 = register A |
| alu_b_sel | output | 2 | ALU B operand: 0 = register B, 1 = 4, 2 = immediate, 3 = immediate shifted by 2 |
| alu_op | output | 3 | ALU operation code |

## Verification
The bench runs all 64 opcodes through a full instruction, which separates the five legal paths from the illegal return path and shows the cycle count of each. Non-branch opcodes run with alu_zero high and a subtract function code, so any leak of either input into the PC strobe or the ALU operation shows up. The branch runs with both values of alu_zero to separate a taken branch from a fall-through. All 64 function codes are swept through the register-type path to check the ALU operation map, including the add fallback for unknown codes.

// File: rtl/mcyc_pkg.sv
package mcyc_pkg;
  localparam int OP_W    = 6;
  localparam int FN_W    = 6;
  localparam int ALUOP_W = 3;
  localparam int BSEL_W  = 2;
  localparam int PCSRC_W = 2;

  localparam logic [OP_W-1:0] OPC_RTYPE = 6'h00;
  localparam logic [OP_W-1:0] OPC_LOAD  = 6'h23;
  localparam logic [OP_W-1:0] OPC_STORE = 6'h2B;
  localparam logic [OP_W-1:0] OPC_BEQ   = 6'h04;
  localparam logic [OP_W-1:0] OPC_JUMP  = 6'h02;

  localparam logic [FN_W-1:0] FN_ADD = 6'h20;
  localparam logic [FN_W-1:0] FN_SUB = 6'h22;
  localparam logic [FN_W-1:0] FN_AND = 6'h24;
  localparam logic [FN_W-1:0] FN_OR  = 6'h25;
  localparam logic [FN_W-1:0] FN_SLT = 6'h2A;

  localparam logic [ALUOP_W-1:0] ALU_AND = 3'b000;
  localparam logic [ALUOP_W-1:0] ALU_OR  = 3'b001;
  localparam logic [ALUOP_W-1:0] ALU_ADD = 3'b010;
  localparam logic [ALUOP_W-1:0] ALU_SUB = 3'b110;
  localparam logic [ALUOP_W-1:0] ALU_SLT = 3'b111;

  localparam logic [BSEL_W-1:0] BSEL_REG    = 2'd0;
  localparam logic [BSEL_W-1:0] BSEL_FOUR   = 2'd1;
  localparam logic [BSEL_W-1:0] BSEL_IMM    = 2'd2;
  localparam logic [BSEL_W-1:0] BSEL_IMM_SH = 2'd3;

  localparam logic [PCSRC_W-1:0] PCSRC_ALU = 2'd0;
  localparam logic [PCSRC_W-1:0] PCSRC_TGT = 2'd1;
  localparam logic [PCSRC_W-1:0] PCSRC_JMP = 2'd2;

  typedef enum logic [3:0] {
    ST_FETCH, ST_DECODE, ST_ADDR, ST_MEMRD, ST_MEMWR,
    ST_WBMEM, ST_EXEC, ST_WBALU, ST_CMP, ST_JUMP
  } state_t;

  typedef enum logic [2:0] {
    IC_RTYPE, IC_LOAD, IC_STORE, IC_BEQ, IC_JUMP, IC_ILLEGAL
  } iclass_t;
endpackage

// File: rtl/mcyc_opdec.sv
module mcyc_opdec
  import mcyc_pkg::*;
(
  input  logic [OP_W-1:0] opcode,
  output iclass_t         cls
);
  always_comb begin
    case (opcode)
      OPC_RTYPE: cls = IC_RTYPE;
      OPC_LOAD:  cls = IC_LOAD;
      OPC_STORE: cls = IC_STORE;
      OPC_BEQ:   cls = IC_BEQ;
      OPC_JUMP:  cls = IC_JUMP;
      default:   cls = IC_ILLEGAL;
    endcase
  end
endmodule

// File: rtl/mcyc_aluctl.sv
module mcyc_aluctl
  import mcyc_pkg::*;
(
  input  logic [FN_W-1:0]    funct,
  output logic [ALUOP_W-1:0] fn_op
);
  always_comb begin
    case (funct)
      FN_ADD:  fn_op = ALU_ADD;
      FN_SUB:  fn_op = ALU_SUB;
      FN_AND:  fn_op = ALU_AND;
      FN_OR:   fn_op = ALU_OR;
      FN_SLT:  fn_op = ALU_SLT;
      default: fn_op = ALU_ADD;
    endcase
  end
endmodule

// File: rtl/mcyc_seq.sv
module mcyc_seq
  import mcyc_pkg::*;
(
  input  logic    clk,
  input  logic    rst_n,
  input  iclass_t cls,
  output state_t  state
);
  state_t nxt;

  always_comb begin
    nxt = ST_FETCH;
    case (state)
      ST_FETCH:  nxt = ST_DECODE;
      ST_DECODE: begin
        case (cls)
          IC_LOAD, IC_STORE: nxt = ST_ADDR;
          IC_RTYPE:          nxt = ST_EXEC;
          IC_BEQ:            nxt = ST_CMP;
          IC_JUMP:           nxt = ST_JUMP;
          default:           nxt = ST_FETCH;
        endcase
      end
      ST_ADDR:   nxt = (cls == IC_LOAD) ? ST_MEMRD : ST_MEMWR;
      ST_MEMRD:  nxt = ST_WBMEM;
      ST_EXEC:   nxt = ST_WBALU;
      default:   nxt = ST_FETCH;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_FETCH;
    else        state <= nxt;
  end

  // R2: decode always follows fetch
  p_decode_after_fetch_r2: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_FETCH |=> state == ST_DECODE);
  // R3: a read is always followed by its write-back, then fetch
  p_read_then_wb_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_MEMRD |=> state == ST_WBMEM);
  p_wb_then_fetch_r3: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_WBMEM |=> state == ST_FETCH);
  // R7: the compare cycle ends the branch
  p_cmp_then_fetch_r7: assert property (@(posedge clk) disable iff (!rst_n)
    state == ST_CMP |=> state == ST_FETCH);
  // R10: an illegal opcode returns to fetch from decode
  p_illegal_to_fetch_r10: assert property (@(posedge clk) disable iff (!rst_n)
    (state == ST_DECODE && cls == IC_ILLEGAL) |=> state == ST_FETCH);
endmodule

// File: rtl/mcyc_strobes.sv
module mcyc_strobes
  import mcyc_pkg::*;
(
  input  logic               clk,
  input  logic               rst_n,
  input  state_t             state,
  input  logic               alu_zero,
  input  logic [ALUOP_W-1:0] fn_op,
  output logic               mem_addr_alu,
  output logic               mem_rd,
  output logic               mem_wr,
  output logic               ir_we,
  output logic               pc_we,
  output logic [PCSRC_W-1:0] pc_src,
  output logic               tgt_we,
  output logic               rf_we,
  output logic               rf_dst_rd,
  output logic               rf_src_mem,
  output logic               alu_a_reg,
  output logic [BSEL_W-1:0]  alu_b_sel,
  output logic [ALUOP_W-1:0] alu_op
);
  always_comb begin
    mem_addr_alu = 1'b0;
    mem_rd       = 1'b0;
    mem_wr       = 1'b0;
    ir_we        = 1'b0;
    pc_we        = 1'b0;
    pc_src       = PCSRC_ALU;
    tgt_we       = 1'b0;
    rf_we        = 1'b0;
    rf_dst_rd    = 1'b0;
    rf_src_mem   = 1'b0;
    alu_a_reg    = 1'b0;
    alu_b_sel    = BSEL_REG;
    alu_op       = ALU_ADD;
    case (state)
      ST_FETCH: begin
        mem_rd    = 1'b1;
        ir_we     = 1'b1;
        pc_we     = 1'b1;
        alu_b_sel = BSEL_FOUR;
      end
      ST_DECODE: begin
        tgt_we    = 1'b1;
        alu_b_sel = BSEL_IMM_SH;
      end
      ST_ADDR: begin
        alu_a_reg = 1'b1;
        alu_b_sel = BSEL_IMM;
      end
      ST_MEMRD: begin
        mem_addr_alu = 1'b1;
        mem_rd       = 1'b1;
      end
      ST_MEMWR: begin
        mem_addr_alu = 1'b1;
        mem_wr       = 1'b1;
      end
      ST_WBMEM: begin
        rf_we      = 1'b1;
        rf_src_mem = 1'b1;
      end
      ST_EXEC: begin
        alu_a_reg = 1'b1;
        alu_op    = fn_op;
      end
      ST_WBALU: begin
        rf_we     = 1'b1;
        rf_dst_rd = 1'b1;
      end
      ST_CMP: begin
        alu_a_reg = 1'b1;
        alu_op    = ALU_SUB;
        if (alu_zero) begin
          pc_we  = 1'b1;
          pc_src = PCSRC_TGT;
        end
      end
      ST_JUMP: begin
        pc_we  = 1'b1;
        pc_src = PCSRC_JMP;
      end
      default: ;
    endcase
  end

  // R11: write strobes never overlap, read and write never overlap
  p_one_write_r11: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({mem_wr, rf_we, tgt_we, ir_we}));
  p_no_rd_wr_r11: assert property (@(posedge clk) disable iff (!rst_n)
    !(mem_rd && mem_wr));
  // R7: the PC takes the target register only on equality
  p_tgt_needs_zero_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (pc_we && pc_src == PCSRC_TGT) |-> alu_zero);
  // R4: a memory write always uses the ALU address
  p_wr_uses_alu_addr_r4: assert property (@(posedge clk) disable iff (!rst_n)
    mem_wr |-> mem_addr_alu);
  // R2: the target register loads the cycle after the instruction register
  p_tgt_after_ir_r2: assert property (@(posedge clk) disable iff (!rst_n)
    ir_we |=> tgt_we);
endmodule

// File: rtl/mcyc_ctrl.sv
module mcyc_ctrl
  import mcyc_pkg::*;
(
  input  logic        clk,
  input  logic        rst_n,
  input  logic [5:0]  opcode,
  input  logic [5:0]  funct,
  input  logic        alu_zero,
  output logic        mem_addr_alu,
  output logic        mem_rd,
  output logic        mem_wr,
  output logic        ir_we,
  output logic        pc_we,
  output logic [1:0]  pc_src,
  output logic        tgt_we,
  output logic        rf_we,
  output logic        rf_dst_rd,
  output logic        rf_src_mem,
  output logic        alu_a_reg,
  output logic [1:0]  alu_b_sel,
  output logic [2:0]  alu_op
);
  iclass_t            cls;
  state_t             state;
  logic [ALUOP_W-1:0] fn_op;

  mcyc_opdec u_opdec (.opcode(opcode), .cls(cls));
  mcyc_aluctl u_aluctl (.funct(funct), .fn_op(fn_op));
  mcyc_seq u_seq (.clk(clk), .rst_n(rst_n), .cls(cls), .state(state));
  mcyc_strobes u_strobes (
    .clk(clk), .rst_n(rst_n), .state(state), .alu_zero(alu_zero), .fn_op(fn_op),
    .mem_addr_alu(mem_addr_alu), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_we(ir_we),
    .pc_we(pc_we), .pc_src(pc_src), .tgt_we(tgt_we), .rf_we(rf_we),
    .rf_dst_rd(rf_dst_rd), .rf_src_mem(rf_src_mem), .alu_a_reg(alu_a_reg),
    .alu_b_sel(alu_b_sel), .alu_op(alu_op)
  );
endmodule

// File: tb/tb_mcyc_ctrl.sv
`timescale 1ns/1ps
module tb_mcyc_ctrl;
  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [5:0] opcode = 6'h00;
  logic [5:0] funct = 6'h00;
  logic alu_zero = 1'b0;
  logic mem_addr_alu, mem_rd, mem_wr, ir_we, pc_we, tgt_we, rf_we;
  logic rf_dst_rd, rf_src_mem, alu_a_reg;
  logic [1:0] pc_src, alu_b_sel;
  logic [2:0] alu_op;
  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #10 clk = ~clk;

  mcyc_ctrl dut (
    .clk(clk), .rst_n(rst_n), .opcode(opcode), .funct(funct), .alu_zero(alu_zero),
    .mem_addr_alu(mem_addr_alu), .mem_rd(mem_rd), .mem_wr(mem_wr), .ir_we(ir_we),
    .pc_we(pc_we), .pc_src(pc_src), .tgt_we(tgt_we), .rf_we(rf_we),
    .rf_dst_rd(rf_dst_rd), .rf_src_mem(rf_src_mem), .alu_a_reg(alu_a_reg),
    .alu_b_sel(alu_b_sel), .alu_op(alu_op)
  );

  localparam int S_F = 0, S_D = 1, S_A = 2, S_MR = 3, S_MW = 4;
  localparam int S_WM = 5, S_X = 6, S_WR = 7, S_C = 8, S_J = 9;

  function automatic logic [2:0] op_for(input logic [5:0] fn);
    case (fn)
      6'h20: return 3'b010;
      6'h22: return 3'b110;
      6'h24: return 3'b000;
      6'h25: return 3'b001;
      6'h2A: return 3'b111;
      default: return 3'b010;
    endcase
  endfunction

  // packed as {addr,rd,wr,ir,pcwe,pcsrc[2],tgt,rfwe,dst,srcmem,a,b[2],op[3]}
  function automatic logic [16:0] expv(input int s, input logic [5:0] fn, input logic z);
    logic ad = 0, rd = 0, wr = 0, ir = 0, pw = 0, tg = 0, rw = 0, ds = 0, sm = 0, a = 0;
    logic [1:0] ps = 0, b = 0;
    logic [2:0] op = 3'b010;
    case (s)
      S_F:  begin rd = 1; ir = 1; pw = 1; b = 1; end
      S_D:  begin tg = 1; b = 3; end
      S_A:  begin a = 1; b = 2; end
      S_MR: begin ad = 1; rd = 1; end
      S_MW: begin ad = 1; wr = 1; end
      S_WM: begin rw = 1; sm = 1; end
      S_X:  begin a = 1; op = op_for(fn); end
      S_WR: begin rw = 1; ds = 1; end
      S_C:  begin a = 1; op = 3'b110; if (z) begin pw = 1; ps = 1; end end
      S_J:  begin pw = 1; ps = 2; end
      default: ;
    endcase
    return {ad, rd, wr, ir, pw, ps, tg, rw, ds, sm, a, b, op};
  endfunction

  function automatic logic [16:0] got_v();
    return {mem_addr_alu, mem_rd, mem_wr, ir_we, pc_we, pc_src, tgt_we, rf_we,
            rf_dst_rd, rf_src_mem, alu_a_reg, alu_b_sel, alu_op};
  endfunction

  task automatic check_step(input int s, input string tag);
    logic [16:0] e, g;
    e = expv(s, funct, alu_zero);
    g = got_v();
    checks++;
    if (g !== e) begin
      errors++;
      $display("FAIL %s op=%h fn=%h z=%b step=%0d: got %b expected %b",
               tag, opcode, funct, alu_zero, s, g, e);
    end
    checks++;
    if (!$onehot0({mem_wr, rf_we, tgt_we, ir_we}) || (mem_rd && mem_wr)) begin
      errors++;
      $display("FAIL R11 op=%h step=%0d: got strobes %b expected at most one",
               opcode, s, {mem_wr, rf_we, tgt_we, ir_we, mem_rd});
    end
  endtask

  task automatic next_cycle();
    @(posedge clk);
    @(negedge clk);
    #1;
  endtask

  task automatic run_instr(input logic [5:0] op, input logic [5:0] fn, input logic z);
    int steps[4];
    int n;
    string tag;
    opcode = op; funct = fn; alu_zero = z;
    #1;
    check_step(S_F, "R1");
    next_cycle();
    check_step(S_D, "R2");
    case (op)
      6'h23: begin steps = '{S_A, S_MR, S_WM, S_F}; n = 3; tag = "R3"; end
      6'h2B: begin steps = '{S_A, S_MW, S_F, S_F}; n = 2; tag = "R4"; end
      6'h00: begin steps = '{S_X, S_WR, S_F, S_F}; n = 2; tag = "R5"; end
      6'h04: begin steps = '{S_C, S_F, S_F, S_F}; n = 1; tag = z ? "R7" : "R8"; end
      6'h02: begin steps = '{S_J, S_F, S_F, S_F}; n = 1; tag = "R9"; end
      default: begin steps = '{S_F, S_F, S_F, S_F}; n = 0; tag = "R10"; end
    endcase
    for (int i = 0; i < n; i++) begin
      next_cycle();
      check_step(steps[i], (steps[i] == S_X) ? "R6" : tag);
    end
    next_cycle();
    check_step(S_F, tag);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    #1;
    check_step(S_F, "R1");
    @(negedge clk);
    rst_n = 1'b1;
    // all opcodes; zero high and a subtract code must not leak (R8, R6)
    for (int op = 0; op < 64; op++) begin
      run_instr(6'(op), 6'h22, 1'b1);
      if (op == 4) run_instr(6'(op), 6'h22, 1'b0);
    end
    // all function codes through the register-type path (R6)
    for (int fn = 0; fn < 64; fn++) run_instr(6'h00, 6'(fn), fn[0]);
    done = 1'b1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    if (!done) begin
      checks++;
      errors++;
      $display("FAIL watchdog: got no completion expected end of sweep");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end
endmodule